// File: doc/BRIEF.md
# Beam-Steering Array Controller

This controller sits beside a cluster of cores whose transceivers each carry a coarse phase shifter. Cores that want a directional channel hand over a wireless packet together with the destination node's mesh row and column. The controller places each packet in a small queue. For each packet it compares the destination's row and column with the cluster's own position, which is fixed by parameters, and derives a beam direction from that comparison.

The direction selects an entry in a writable beam table. Each entry holds one 2-bit phase code per antenna. In the following cycle the controller drives those codes onto the phase-shifter outputs and forwards the packet to the transceivers. Direction evaluation and dispatch are split over two pipeline registers, so one packet can be evaluated while the previous one is being sent. The transceiver side can hold dispatch off with a busy flag. When no directional traffic is being sent, every antenna falls back to the 0° code, which is the omnidirectional setting.

Top module: `beam_steer_ctrl`

## Requirements
- R1: A packet is taken when `in_valid` and `in_ready` are both high at a rising clock edge. The queue holds 4 packets. `in_ready` is low while 4 packets are waiting in the queue behind a stalled evaluation stage.
- R2: When the destination column equals the cluster column, a destination row below the cluster row selects direction 1 (north), and a row above it selects direction 2 (south).
- R3: When the destination row equals the cluster row, a destination column above the cluster column selects direction 3 (east), and a column below it selects direction 4 (west).
- R4: Any other destination, including the cluster's own address, selects direction 0 (omni). `trx_dir` never exceeds 4.
- R5: On dispatch, `phase` equals the beam-table entry of the chosen direction. Antenna k takes bits [2k+1:2k], coded 00=0°, 01=90°, 10=180°, 11=270°.
- R6: With `trx_busy` low, `trx_valid` pulses high for one cycle right after the second rising edge that follows the accepting edge. The pulse carries the packet's data and direction. Packets leave in arrival order.
- R7: While `trx_busy` is high, no packet is dispatched. No queued packet is lost, and all of them leave in order once busy falls.
- R8: After reset, every table entry is zero, `phase` is zero, `trx_valid` is low and `in_ready` is high.
- R9: Between dispatches, `phase` holds its value while `trx_busy` is high. It returns to all zeros at the first edge without a dispatch at which `trx_busy` is low.
- R10: A write of `tbl_data` to entry `tbl_addr` with `tbl_we` high takes effect at that edge and is used by every later dispatch of that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet offered by a core |
| in_ready | output | 1 | Queue has room |
| in_dst_row | input | ROW_W | Destination row |
| in_dst_col | input | COL_W | Destination column |
| in_data | input | DATA_W | Packet payload |
| tbl_we | input | 1 | Beam-table write strobe |
| tbl_addr | input | 3 | Direction entry to write |
| tbl_data | input | 2*N_ANT | Phase vector to store |
| trx_busy | input | 1 | Transceivers still transmitting |
| trx_valid | output | 1 | Packet dispatched this cycle |
| trx_dir | output | 3 | Direction used for the dispatch |
| trx_data | output | DATA_W | Dispatched payload |
| phase | output | 2*N_ANT | Phase code per antenna |

## Verification
A packet accepted at one edge appears on the transceiver outputs after the second edge that follows. The bench therefore waits two falling edges after the accepting edge before it samples `trx_valid`, `trx_dir`, `phase` and `trx_data`. It samples once more one cycle later to see the phase fall back to zero. Table writes are checked on the first dispatch after the writing edge. Under busy, the bench fills the queue and confirms that nothing leaves. It then releases busy and checks that the packets come out in arrival order on consecutive cycles, with every sample taken at a falling edge.

// File: rtl/beam_steer_ctrl.sv
module beam_steer_ctrl #(
  parameter int N_ANT  = 4,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int MY_ROW = 3,
  parameter int MY_COL = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ROW_W-1:0]     in_dst_row,
  input  logic [COL_W-1:0]     in_dst_col,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 tbl_we,
  input  logic [2:0]           tbl_addr,
  input  logic [2*N_ANT-1:0]   tbl_data,
  input  logic                 trx_busy,
  output logic                 trx_valid,
  output logic [2:0]           trx_dir,
  output logic [DATA_W-1:0]    trx_data,
  output logic [2*N_ANT-1:0]   phase
);
  localparam int PV_W  = 2 * N_ANT;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = ROW_W + COL_W + DATA_W;
  localparam int N_DIR = 8;
  localparam logic [ROW_W-1:0] HOME_R = ROW_W'(MY_ROW);
  localparam logic [COL_W-1:0] HOME_C = COL_W'(MY_COL);
  localparam logic [2:0] D_OMNI = 3'd0, D_NORTH = 3'd1, D_SOUTH = 3'd2,
                         D_EAST = 3'd3, D_WEST = 3'd4;

  logic [ENT_W-1:0] q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic [PV_W-1:0]  tbl [N_DIR];

  logic              s1_v;
  logic [2:0]        s1_dir;
  logic [DATA_W-1:0] s1_data;

  logic push, pop, dispatch;
  logic [ROW_W-1:0]  h_row;
  logic [COL_W-1:0]  h_col;
  logic [DATA_W-1:0] h_data;
  logic [2:0]        h_dir;

  assign in_ready = cnt < CNT_W'(DEPTH);
  assign push     = in_valid && in_ready;
  assign dispatch = s1_v && !trx_busy;
  assign pop      = (cnt != '0) && (!s1_v || dispatch);
  assign {h_row, h_col, h_data} = q[rd_ptr];

  always_comb begin
    h_dir = D_OMNI;
    if (h_col == HOME_C && h_row != HOME_R)
      h_dir = (h_row < HOME_R) ? D_NORTH : D_SOUTH;
    else if (h_row == HOME_R && h_col != HOME_C)
      h_dir = (h_col > HOME_C) ? D_EAST : D_WEST;
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) q[wr_ptr] <= {in_dst_row, in_dst_col, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_DIR; i++) tbl[i] <= '0;
    end else if (tbl_we) begin
      tbl[tbl_addr] <= tbl_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_dir  <= D_OMNI;
      s1_data <= '0;
    end else if (!s1_v || dispatch) begin
      s1_v <= pop;
      if (pop) begin
        s1_dir  <= h_dir;
        s1_data <= h_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trx_valid <= 1'b0;
      trx_dir   <= D_OMNI;
      trx_data  <= '0;
      phase     <= '0;
    end else begin
      trx_valid <= dispatch;
      if (dispatch) begin
        trx_dir  <= s1_dir;
        trx_data <= s1_data;
        phase    <= tbl[s1_dir];
      end else if (!trx_busy) begin
        phase <= '0;
      end
    end
  end

  a_r1_ready_falls_on_push: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));
  a_r4_dir_range: assert property (@(posedge clk) disable iff (!rst_n)
    trx_valid |-> trx_dir <= 3'd4);
  a_r6_from_stage: assert property (@(posedge clk) disable iff (!rst_n)
    trx_valid |-> $past(s1_v));
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    trx_busy |=> !trx_valid);
  a_r9_idle_omni: assert property (@(posedge clk) disable iff (!rst_n)
    (!trx_valid && !$past(trx_busy)) |-> phase == '0);
endmodule

// File: tb/test_beam_steer_ctrl.sv
module test_beam_steer_ctrl;
  localparam int N_ANT = 4, ROW_W = 3, COL_W = 3, DATA_W = 16;
  localparam int NV = 8;
  // {dst_row, dst_col, expected dir}; cluster sits at row 3, column 3
  localparam logic [8:0] VEC [NV] = '{
    {3'd1, 3'd3, 3'd1}, {3'd6, 3'd3, 3'd2}, {3'd3, 3'd5, 3'd3}, {3'd3, 3'd0, 3'd4},
    {3'd3, 3'd3, 3'd0}, {3'd5, 3'd5, 3'd0}, {3'd0, 3'd3, 3'd1}, {3'd7, 3'd3, 3'd2}};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [ROW_W-1:0] in_dst_row = '0;
  logic [COL_W-1:0] in_dst_col = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic tbl_we = 0;
  logic [2:0] tbl_addr = '0;
  logic [2*N_ANT-1:0] tbl_data = '0;
  logic trx_busy = 0, trx_valid;
  logic [2:0] trx_dir;
  logic [DATA_W-1:0] trx_data;
  logic [2*N_ANT-1:0] phase;
  logic [7:0] exp_tbl [8];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  beam_steer_ctrl #(.N_ANT(N_ANT), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W))
    i_beam_steer_ctrl (.clk, .rst_n, .in_valid, .in_ready, .in_dst_row, .in_dst_col,
      .in_data, .tbl_we, .tbl_addr, .tbl_data, .trx_busy, .trx_valid, .trx_dir,
      .trx_data, .phase);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_tbl(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); tbl_we = 1; tbl_addr = a; tbl_data = d;
    @(negedge clk); tbl_we = 0;
    exp_tbl[a] = d;
  endtask

  task automatic send(input logic [2:0] r, input logic [2:0] c, input logic [15:0] d);
    @(negedge clk); in_valid = 1; in_dst_row = r; in_dst_col = c; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_tbl[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 in_ready", in_ready, 1);
    chk("R8 trx_valid", trx_valid, 0);
    chk("R8 phase", phase, 0);
    rst_n = 1;

    // R4/R8: omni entry untouched since reset reads all zeros
    send(3'd3, 3'd3, 16'h0AA0);
    @(negedge clk); @(negedge clk);
    chk("R8 reset table entry", phase, 0);
    chk("R6 valid", trx_valid, 1);

    wr_tbl(3'd1, 8'hE4); // 0,90,180,270
    wr_tbl(3'd2, 8'h1B); // 270,180,90,0
    wr_tbl(3'd3, 8'h44); // 0,90,0,90
    wr_tbl(3'd4, 8'hCC); // 0,270,0,270

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][8:6], VEC[v][5:3], 16'h1000 + 16'(v));
      @(negedge clk); @(negedge clk);
      chk("R6 trx_valid", trx_valid, 1);
      chk("R2/R3/R4 trx_dir", trx_dir, VEC[v][2:0]);
      chk("R5 phase", phase, exp_tbl[VEC[v][2:0]]);
      chk("R6 trx_data", trx_data, 16'h1000 + 16'(v));
      @(negedge clk);
      chk("R6 single pulse", trx_valid, 0);
      chk("R9 back to omni", phase, 0);
    end

    // R9 phase held while busy
    send(3'd0, 3'd3, 16'h2222);
    @(negedge clk); @(negedge clk);
    chk("R5 north", phase, 8'hE4);
    trx_busy = 1;
    @(negedge clk);
    chk("R9 held under busy", phase, 8'hE4);
    trx_busy = 0;
    @(negedge clk);
    chk("R9 cleared after busy", phase, 0);

    // R10 table rewrite used by next dispatch
    wr_tbl(3'd3, 8'h99);
    send(3'd3, 3'd6, 16'h3333);
    @(negedge clk); @(negedge clk);
    chk("R10 new entry", phase, 8'h99);
    chk("R3 east", trx_dir, 3);

    // R1/R7 busy stall and queue fill
    trx_busy = 1;
    for (int k = 0; k < 5; k++) send(3'd3, 3'd1, 16'h4000 + 16'(k));
    @(negedge clk);
    chk("R1 ready low when full", in_ready, 0);
    chk("R7 no dispatch while busy", trx_valid, 0);
    begin
      int got = 0;
      trx_busy = 0;
      for (int t = 0; t < 20; t++) begin
        @(negedge clk);
        if (trx_valid) begin
          chk("R7 order", trx_data, 16'h4000 + 16'(got));
          got++;
        end
      end
      chk("R7 all delivered", got, 5);
    end
    chk("R1 ready after drain", in_ready, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule